// File: doc/BRIEF.md
# ADC control and status sequencer

This block sits between a CPU register bus and an analog-to-digital converter core. Software programs one 8-bit control/status register that holds a completion flag, an interrupt enable, a continuous-mode select and a channel code. Each write that carries a usable channel code starts a conversion on that channel. The result is captured into a low and a high result byte. Completion sets the flag and, when enabled, an interrupt request. In continuous mode the block restarts the converter back to back on the same channel.

The converter core is reached through a plain handshake. The block pulses a start strobe for one clock together with the channel code. It then waits for a done pulse that carries a 10-bit data word. The all-ones channel code switches the converter off. A high result byte latched at each low-byte read lets software read the 10-bit result as one coherent pair.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x1F, the interrupt output is low and no start strobe is issued.
- R2: Address 0 is the control register: bit 7 completion flag, bit 6 interrupt enable, bit 5 continuous select (1 = continuous), bits 4:0 channel code. The written bits 6:0 read back unchanged.
- R3: Bit 7 of a write to address 0 is ignored; the flag cannot be set by software.
- R4: A write to address 0 with a channel code other than 11111 clears the flag, aborts any conversion in progress, and raises the start strobe for exactly one clock in the following cycle with that channel code on the channel output.
- R5: A write to address 0 with channel code 11111 clears the flag, aborts any conversion in progress, and issues no start strobe.
- R6: A done pulse while a conversion is pending captures the data word and sets the flag. Address 2 reads data bits 7:0. Address 1 carries data bits 9:8 in its bits 1:0, with its upper bits zero. A done pulse while no conversion is pending changes neither the flag nor the result.
- R7: A conversion on channel code 01000 (grounded input) produces a result of zero whatever data the converter returns.
- R8: The interrupt output is high exactly while both the flag and the interrupt enable are 1.
- R9: In single mode (bit 5 = 0) exactly one conversion runs per write; no further start strobe follows its completion.
- R10: In continuous mode a new start strobe follows each completion on the same channel; each completion overwrites the result, and the flag stays set until a read or write clears it.
- R11: A read of address 2 clears the flag.
- R12: A read of address 1 returns the high bits latched at the most recent read of address 2, not those of a later conversion.
- R13: Writes to addresses 1, 2 and 3 change no register; address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-clock start strobe to the converter |
| conv_chan | output | 5 | Channel code for the converter |
| conv_done | input | 1 | Conversion finished, data valid |
| conv_data | input | 10 | Conversion data word |

## Verification
The hardest states to reach from the ports are those where old and new data coexist. One is a conversion aborted by a second write before its done pulse. The other is a latched high byte that no longer matches the current result. The bench acts as the converter model and times its done pulses against the bus traffic. It answers the first strobe, rewrites the register before any done, and checks that a fresh strobe carries the new channel. It also reads the low byte of one conversion, runs a second conversion with different upper bits, and only then reads the high byte.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_LO   = 2'd2;

endpackage

// File: rtl/adc_seq_csr.sv
`timescale 1ns/1ps
module adc_seq_csr #(
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_aien,
    input  logic              wr_cont,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              cmp_evt,
    input  logic              rd_lo,
    output logic              flag_o,
    output logic              aien_o,
    output logic              cont_o,
    output logic [CHAN_W-1:0] chan_o
);

    typedef struct packed {
        logic              flag;
        logic              aien;
        logic              cont;
        logic [CHAN_W-1:0] chan;
    } csr_t;

    localparam csr_t CSR_RST = '{flag: 1'b0, aien: 1'b0, cont: 1'b0, chan: '1};

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (wr_en) begin
            csr_d.flag = 1'b0;
            csr_d.aien = wr_aien;
            csr_d.cont = wr_cont;
            csr_d.chan = wr_chan;
        end else if (cmp_evt) begin
            csr_d.flag = 1'b1;
        end else if (rd_lo) begin
            csr_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= CSR_RST;
        else        csr_q <= csr_d;
    end

    assign flag_o = csr_q.flag;
    assign aien_o = csr_q.aien;
    assign cont_o = csr_q.cont;
    assign chan_o = csr_q.chan;

endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              cont,
    input  logic              done,
    output logic              start_o,
    output logic              evt_o
);

    localparam logic [CHAN_W-1:0] OFF_CODE = '1;

    typedef struct packed {
        seq_state_e state;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic evt_d;

    always_comb begin
        fsm_d = fsm_q;
        evt_d = 1'b0;
        if (wr_en) begin
            fsm_d.state = (wr_chan == OFF_CODE) ? ST_IDLE : ST_START;
        end else begin
            case (fsm_q.state)
                ST_START: fsm_d.state = ST_WAIT;
                ST_WAIT: begin
                    if (done) begin
                        evt_d       = 1'b1;
                        fsm_d.state = cont ? ST_START : ST_IDLE;
                    end
                end
                default: fsm_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: ST_IDLE};
        else        fsm_q <= fsm_d;
    end

    assign start_o = (fsm_q.state == ST_START);
    assign evt_o   = evt_d;

endmodule

// File: rtl/adc_seq_result.sv
`timescale 1ns/1ps
module adc_seq_result #(
    parameter int CHAN_W   = 5,
    parameter int RES_W    = 10,
    parameter int LO_W     = 8,
    parameter int GND_CODE = 8,
    localparam int HI_W    = RES_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_evt,
    input  logic [RES_W-1:0]  data,
    input  logic [CHAN_W-1:0] chan,
    input  logic              rd_lo,
    output logic [LO_W-1:0]   lo_o,
    output logic [HI_W-1:0]   hi_o
);

    localparam logic [CHAN_W-1:0] GND = CHAN_W'(GND_CODE);

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [HI_W-1:0]  hi_lat;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (rd_lo) res_d.hi_lat = res_q.res[RES_W-1:LO_W];
        if (cmp_evt) res_d.res = (chan == GND) ? '0 : data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign lo_o = res_q.res[LO_W-1:0];
    assign hi_o = res_q.hi_lat;

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W   = 5,
    parameter int RES_W    = 10,
    parameter int GND_CODE = 8,
    localparam int REG_W   = CHAN_W + 3,
    localparam int HI_W    = RES_W - REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data
);

    logic              wr_ctrl, rd_lo;
    logic              flag_w, aien_w, cont_w, cmp_evt_w;
    logic [CHAN_W-1:0] chan_w;
    logic [REG_W-1:0]  res_lo_w;
    logic [HI_W-1:0]   res_hi_w;
    logic              unused_flag_bit;

    assign wr_ctrl         = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
    assign rd_lo           = bus_sel & ~bus_wr & (bus_addr == ADDR_LO);
    assign unused_flag_bit = bus_wdata[REG_W-1];

    adc_seq_csr #(.CHAN_W(CHAN_W)) csr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ctrl),
        .wr_aien (bus_wdata[CHAN_W+1]),
        .wr_cont (bus_wdata[CHAN_W]),
        .wr_chan (bus_wdata[CHAN_W-1:0]),
        .cmp_evt (cmp_evt_w),
        .rd_lo   (rd_lo),
        .flag_o  (flag_w),
        .aien_o  (aien_w),
        .cont_o  (cont_w),
        .chan_o  (chan_w)
    );

    adc_seq_fsm #(.CHAN_W(CHAN_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ctrl),
        .wr_chan (bus_wdata[CHAN_W-1:0]),
        .cont    (cont_w),
        .done    (conv_done),
        .start_o (conv_start),
        .evt_o   (cmp_evt_w)
    );

    adc_seq_result #(
        .CHAN_W   (CHAN_W),
        .RES_W    (RES_W),
        .LO_W     (REG_W),
        .GND_CODE (GND_CODE)
    ) res_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_evt (cmp_evt_w),
        .data    (conv_data),
        .chan    (chan_w),
        .rd_lo   (rd_lo),
        .lo_o    (res_lo_w),
        .hi_o    (res_hi_w)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {flag_w, aien_w, cont_w, chan_w};
            ADDR_HI:   bus_rdata = {{(REG_W-HI_W){1'b0}}, res_hi_w};
            ADDR_LO:   bus_rdata = res_lo_w;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq       = flag_w & aien_w;
    assign conv_chan = chan_w;

endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
    parameter int CHAN_W = 5,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              irq,
    input logic              flag,
    input logic              cmp_evt,
    input logic [REG_W-1:0]  res_lo
);

    logic wr_ctrl, rd_lo;
    assign wr_ctrl = bus_sel & bus_wr & (bus_addr == 2'd0);
    assign rd_lo   = bus_sel & ~bus_wr & (bus_addr == 2'd2);

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R5
    no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != {CHAN_W{1'b1}}));

    // R4
    wr_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !flag);

    // R6
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> flag);

    // R11
    rd_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !cmp_evt) |=> !flag);

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmp_evt));

    // R13
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_evt |=> $stable(res_lo));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CHAN_W(CHAN_W), .REG_W(REG_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .irq        (irq),
    .flag       (flag_w),
    .cmp_evt    (cmp_evt_w),
    .res_lo     (res_lo_w)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       conv_start;
    logic [4:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = 10'd0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data)
    );

    // ctrl, converter data, expected low byte, expected high byte
    localparam logic [33:0] VEC [6] = '{
        {8'h40, 10'h3FF, 8'hFF, 8'h03},
        {8'h01, 10'h000, 8'h00, 8'h00},
        {8'h48, 10'h2AA, 8'h00, 8'h00},
        {8'h1E, 10'h155, 8'h55, 8'h01},
        {8'h4A, 10'h0C3, 8'hC3, 8'h00},
        {8'h11, 10'h280, 8'h80, 8'h02}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_start(input string req, input logic [4:0] exp_chan);
        bit seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (conv_start) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(req, {15'd0, seen}, 16'd1);
        if (seen) check(req, {11'd0, conv_chan}, {11'd0, exp_chan});
    endtask

    task automatic pulse_done(input logic [9:0] d);
        @(negedge clk);
        conv_done = 1'b1; conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic expect_quiet(input string req, input int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_start) seen = 1'b1;
        end
        check(req, {15'd0, seen}, 16'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd0, rd);
        check("R1 ctrl reset", {8'd0, rd}, 16'h001F);
        check("R1 irq reset", {15'd0, irq}, 16'd0);
        expect_quiet("R1 no start after reset", 10);

        // Vector walk: R2 R4 R6 R7 R8 R9 R11
        for (int v = 0; v < 6; v++) begin
            c = VEC[v][33:26];
            bus_write(2'd0, c);
            wait_start("R4 start strobe", c[4:0]);
            bus_read(2'd0, rd);
            check("R2 ctrl readback pending", {8'd0, rd}, {8'd0, 1'b0, c[6:0]});
            pulse_done(VEC[v][25:16]);
            check("R8 irq after completion", {15'd0, irq}, {15'd0, c[6]});
            bus_read(2'd0, rd);
            check("R6 flag set", {8'd0, rd}, {8'd0, 1'b1, c[6:0]});
            bus_read(2'd2, rd);
            check("R6 R7 low byte", {8'd0, rd}, {8'd0, VEC[v][15:8]});
            bus_read(2'd1, rd);
            check("R6 R7 high byte", {8'd0, rd}, {8'd0, VEC[v][7:0]});
            bus_read(2'd0, rd);
            check("R11 flag cleared by low read", {15'd0, rd[7]}, 16'd0);
            check("R8 irq low after clear", {15'd0, irq}, 16'd0);
            expect_quiet("R9 single mode no restart", 6);
        end

        // R6 done while idle ignored (last result 0x280)
        pulse_done(10'h3FF);
        bus_read(2'd0, rd);
        check("R6 idle done no flag", {15'd0, rd[7]}, 16'd0);
        bus_read(2'd2, rd);
        check("R6 idle done no capture", {8'd0, rd}, 16'h0080);

        // R3 flag bit ignored on write (disabled channel, so no start)
        bus_write(2'd0, 8'h9F);
        bus_read(2'd0, rd);
        check("R3 flag not writable", {8'd0, rd}, 16'h001F);

        // R13 result writes ignored, address 3 reads zero
        bus_write(2'd2, 8'h11);
        bus_write(2'd1, 8'h03);
        bus_write(2'd3, 8'hAA);
        bus_read(2'd2, rd);
        check("R13 low unchanged", {8'd0, rd}, 16'h0080);
        bus_read(2'd1, rd);
        check("R13 high unchanged", {8'd0, rd}, 16'h0002);
        bus_read(2'd3, rd);
        check("R13 addr3 zero", {8'd0, rd}, 16'h0000);
        bus_read(2'd0, rd);
        check("R13 ctrl unchanged", {8'd0, rd}, 16'h001F);

        // R4 abort in progress: restart on new channel
        bus_write(2'd0, 8'h01);
        wait_start("R4 first strobe", 5'h01);
        bus_write(2'd0, 8'h02);
        wait_start("R4 abort restart", 5'h02);
        pulse_done(10'h155);
        bus_read(2'd2, rd);
        check("R4 result after abort", {8'd0, rd}, 16'h0055);

        // R5 disable aborts a pending conversion
        bus_write(2'd0, 8'h04);
        wait_start("R5 strobe before disable", 5'h04);
        bus_write(2'd0, 8'h1F);
        pulse_done(10'h3AB);
        bus_read(2'd0, rd);
        check("R5 disabled no flag", {8'd0, rd}, 16'h001F);
        bus_read(2'd2, rd);
        check("R5 disabled no capture", {8'd0, rd}, 16'h0055);
        expect_quiet("R5 no start while off", 8);

        // R10 continuous mode
        bus_write(2'd0, 8'h63);
        wait_start("R10 first strobe", 5'h03);
        pulse_done(10'h201);
        check("R10 irq set", {15'd0, irq}, 16'd1);
        wait_start("R10 restart strobe", 5'h03);
        pulse_done(10'h0AB);
        bus_read(2'd0, rd);
        check("R10 flag stays set", {8'd0, rd}, 16'h00E3);
        bus_read(2'd2, rd);
        check("R10 result overwritten low", {8'd0, rd}, 16'h00AB);
        bus_read(2'd1, rd);
        check("R10 result overwritten high", {8'd0, rd}, 16'h0000);
        bus_write(2'd0, 8'h1F);
        bus_read(2'd0, rd);
        check("R5 stop continuous", {8'd0, rd}, 16'h001F);
        expect_quiet("R5 continuous halted", 8);

        // R12 coherent high byte
        bus_write(2'd0, 8'h05);
        wait_start("R12 strobe A", 5'h05);
        pulse_done(10'h2F0);
        bus_read(2'd2, rd);
        check("R12 low A", {8'd0, rd}, 16'h00F0);
        bus_write(2'd0, 8'h05);
        wait_start("R12 strobe B", 5'h05);
        pulse_done(10'h10F);
        bus_read(2'd1, rd);
        check("R12 high latched from A", {8'd0, rd}, 16'h0002);
        bus_read(2'd2, rd);
        check("R12 low B", {8'd0, rd}, 16'h000F);
        bus_read(2'd1, rd);
        check("R12 high latched from B", {8'd0, rd}, 16'h0001);

        finish_run();
    end

endmodule